// File: doc/BRIEF.md
# Descriptor Done Notification Controller

This block sits at the end of a descriptor-processing channel. When the channel signals that a descriptor has finished, the block decides whether the host should get an interrupt and whether a header should be written back to memory. The header can carry a done code, a status flag, or both. The decision uses five static configuration bits, the done-request bit from the descriptor header, a flag that says whether the descriptor performed an integrity-check-value comparison, and an error indication that travels with the completion strobe.

A header write is presented as a request that stays up until the memory side acknowledges it. Any interrupt owed for that descriptor is delayed until after the acknowledge, so the host never sees the interrupt before the header is in memory. While a write is outstanding, the block reports busy and ignores further completion strobes. An error completion skips every filter and raises an interrupt at once, with no header write.

Top module: `dn_notify_top`

## Requirements
- R1: After reset, `irq_pulse`, `wb_req` and `busy` are all 0.
- R2: When `cfg_irq_en` is 1, an accepted completion that is notified and has no header write gives `irq_pulse` = 1 for exactly the one cycle after the strobe. When `cfg_irq_en` is 0, no done interrupt is raised.
- R3: When `cfg_wb_en` is 1, a notified completion raises `wb_req` in the cycle after the strobe, with `wb_done_code` = DONE_CODE (default 8'hFF). Otherwise `wb_done_code` reads 0 during a request.
- R4: When `cfg_marked_only` = 0, every completion is notified. When it is 1, only completions with `desc_done_req` = 1 are notified, and done interrupts and done writes are suppressed for the others.
- R5: When `cfg_stat_all` is 1, every non-error completion raises a header write with `wb_status_flag` = 1, whatever the mode bit and done-request bit are.
- R6: When `cfg_stat_icv` is 1, a status write (`wb_status_flag` = 1) is raised only for completions with `desc_icv` = 1.
- R7: A done write and a status write owed for the same descriptor are merged into one request carrying both `wb_done_code` = DONE_CODE and `wb_status_flag` = 1.
- R8: An interrupt owed for a descriptor that also has a header write appears as a one-cycle `irq_pulse` in the cycle after the one where `wb_ack` is sampled with `wb_req`. `irq_pulse` is never 1 while `wb_req` is 1.
- R9: A completion with `cmpl_error` = 1 gives `irq_pulse` in the next cycle for every configuration setting, and it raises no header write.
- R10: `wb_req`, `wb_done_code` and `wb_status_flag` hold steady until `wb_ack` is sampled high. `wb_req` falls in the next cycle, and `busy` equals `wb_req`.
- R11: A completion strobe that arrives while `busy` is 1 is dropped. It produces no interrupt and no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_irq_en | input | 1 | Enables the done interrupt |
| cfg_wb_en | input | 1 | Enables the done header write |
| cfg_marked_only | input | 1 | 1: notify only descriptors that request it |
| cfg_stat_all | input | 1 | Status write for every descriptor |
| cfg_stat_icv | input | 1 | Status write for integrity-check descriptors |
| cmpl_valid | input | 1 | One-cycle completion strobe |
| cmpl_error | input | 1 | Completion is an error halt |
| desc_done_req | input | 1 | Done-request bit of the descriptor header |
| desc_icv | input | 1 | Descriptor performed an integrity check |
| wb_ack | input | 1 | Memory side accepted the header write |
| wb_req | output | 1 | Header write request |
| wb_done_code | output | DONE_W | Done code to write, 0 if none |
| wb_status_flag | output | 1 | Status field is to be written |
| irq_pulse | output | 1 | One-cycle interrupt |
| busy | output | 1 | Writeback outstanding; strobes ignored |

## Verification
Two events can coincide: a write acknowledge and a fresh completion strobe in the same cycle, and an interrupt released by an acknowledge together with a new strobe accepted in the next cycle. The bench pulses `cmpl_valid` while a request is still waiting. It then strobes again right after an acknowledge. A behavioural model, advanced on every clock, judges both cases: the first strobe must vanish without trace, and the second must be taken while the released pulse is on its way out.

// File: rtl/dn_pkg.sv
package dn_pkg;

  typedef struct packed {
    logic irq_en;
    logic wb_en;
    logic marked_only;
    logic stat_all;
    logic stat_icv;
  } dn_cfg_t;

  typedef struct packed {
    logic irq_owed;   // interrupt owed for this descriptor
    logic wb_done;    // done code must be written
    logic wb_stat;    // status field must be written
  } dn_plan_t;

  function automatic logic dn_notified(dn_cfg_t c, logic done_req);
    return !c.marked_only || done_req;
  endfunction

  function automatic logic dn_status_due(dn_cfg_t c, logic icv);
    return c.stat_all || (c.stat_icv && icv);
  endfunction

  function automatic dn_plan_t dn_decide(dn_cfg_t c, logic done_req,
                                         logic icv, logic err);
    dn_plan_t p;
    logic n;
    n = dn_notified(c, done_req);
    if (err) begin
      p.irq_owed = 1'b1;
      p.wb_done  = 1'b0;
      p.wb_stat  = 1'b0;
    end else begin
      p.irq_owed = n && c.irq_en;
      p.wb_done  = n && c.wb_en;
      p.wb_stat  = dn_status_due(c, icv);
    end
    return p;
  endfunction

endpackage

// File: rtl/dn_policy.sv
module dn_policy
  import dn_pkg::*;
(
  input  dn_cfg_t  cfg,
  input  logic     done_req,
  input  logic     icv,
  input  logic     err,
  output dn_plan_t plan,
  output logic     needs_wb
);
  always_comb begin
    plan     = dn_decide(cfg, done_req, icv, err);
    needs_wb = plan.wb_done || plan.wb_stat;
  end
endmodule

// File: rtl/dn_wb_track.sv
module dn_wb_track
  import dn_pkg::*;
#(
  parameter int unsigned       DONE_W    = 8,
  parameter logic [DONE_W-1:0] DONE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,      // accepted completion needing a write
  input  dn_plan_t          plan,
  input  logic              ack,
  output logic              pending,
  output logic [DONE_W-1:0] done_code,
  output logic              status_flag,
  output logic              ack_evt,
  output logic              irq_after
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_t;
  st_t  st;
  logic done_q, stat_q, irq_q;

  assign ack_evt = (st == ST_WAIT) && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_WAIT;
          done_q <= plan.wb_done;
          stat_q <= plan.wb_stat;
          irq_q  <= plan.irq_owed;
        end
        ST_WAIT: if (ack) begin
          st     <= ST_IDLE;
          done_q <= 1'b0;
          stat_q <= 1'b0;
          irq_q  <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pending     = (st == ST_WAIT);
  assign done_code   = done_q ? DONE_CODE : '0;
  assign status_flag = stat_q;
  assign irq_after   = ack_evt && irq_q;
endmodule

// File: rtl/dn_irq_pulse.sv
module dn_irq_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire;
  end
endmodule

// File: rtl/dn_notify_top.sv
module dn_notify_top
  import dn_pkg::*;
#(
  parameter int unsigned       DONE_W    = 8,
  parameter logic [DONE_W-1:0] DONE_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_irq_en,
  input  logic              cfg_wb_en,
  input  logic              cfg_marked_only,
  input  logic              cfg_stat_all,
  input  logic              cfg_stat_icv,
  input  logic              cmpl_valid,
  input  logic              cmpl_error,
  input  logic              desc_done_req,
  input  logic              desc_icv,
  input  logic              wb_ack,
  output logic              wb_req,
  output logic [DONE_W-1:0] wb_done_code,
  output logic              wb_status_flag,
  output logic              irq_pulse,
  output logic              busy
);
  dn_cfg_t  cfg;
  dn_plan_t plan;
  logic     needs_wb;
  logic     accept_evt;   // completion taken this cycle
  logic     ack_evt;      // outstanding write acknowledged this cycle
  logic     irq_after;
  logic     irq_fire;

  assign cfg = '{irq_en: cfg_irq_en, wb_en: cfg_wb_en,
                 marked_only: cfg_marked_only,
                 stat_all: cfg_stat_all, stat_icv: cfg_stat_icv};

  dn_policy u_policy (
    .cfg      (cfg),
    .done_req (desc_done_req),
    .icv      (desc_icv),
    .err      (cmpl_error),
    .plan     (plan),
    .needs_wb (needs_wb)
  );

  assign accept_evt = cmpl_valid && !busy;

  dn_wb_track #(.DONE_W(DONE_W), .DONE_CODE(DONE_CODE)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept_evt && needs_wb),
    .plan        (plan),
    .ack         (wb_ack),
    .pending     (busy),
    .done_code   (wb_done_code),
    .status_flag (wb_status_flag),
    .ack_evt     (ack_evt),
    .irq_after   (irq_after)
  );

  assign wb_req   = busy;
  assign irq_fire = (accept_evt && !needs_wb && plan.irq_owed) || irq_after;

  dn_irq_pulse u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (irq_fire),
    .pulse (irq_pulse)
  );
endmodule

// File: rtl/dn_notify_chk.sv
module dn_notify_chk #(
  parameter int unsigned DONE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmpl_valid,
  input logic              cmpl_error,
  input logic              wb_ack,
  input logic              wb_req,
  input logic [DONE_W-1:0] wb_done_code,
  input logic              wb_status_flag,
  input logic              irq_pulse,
  input logic              busy,
  input logic              accept_evt,
  input logic              ack_evt
);
  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_done_code) && $stable(wb_status_flag));

  // R10
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !wb_req);

  // R8
  irq_not_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !wb_req);

  // R9
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && cmpl_error |=> irq_pulse && !wb_req);

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid && busy && !wb_ack |=> wb_req && !irq_pulse);

  // R10
  req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> $past(accept_evt));
endmodule

bind dn_notify_top dn_notify_chk #(.DONE_W(DONE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmpl_valid     (cmpl_valid),
  .cmpl_error     (cmpl_error),
  .wb_ack         (wb_ack),
  .wb_req         (wb_req),
  .wb_done_code   (wb_done_code),
  .wb_status_flag (wb_status_flag),
  .irq_pulse      (irq_pulse),
  .busy           (busy),
  .accept_evt     (accept_evt),
  .ack_evt        (ack_evt)
);

// File: tb/dn_notify_top_test.sv
module dn_notify_top_test;
  localparam logic [7:0] CODE = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_irq = 0, c_wb = 0, c_mark = 0, c_sall = 0, c_sicv = 0;
  logic valid = 0, err = 0, dreq = 0, icv = 0, ack = 0;
  logic wb_req, wb_stat, irq, busy;
  logic [7:0] wb_code;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dn_notify_top uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_irq_en(c_irq), .cfg_wb_en(c_wb), .cfg_marked_only(c_mark),
    .cfg_stat_all(c_sall), .cfg_stat_icv(c_sicv),
    .cmpl_valid(valid), .cmpl_error(err), .desc_done_req(dreq),
    .desc_icv(icv), .wb_ack(ack),
    .wb_req(wb_req), .wb_done_code(wb_code), .wb_status_flag(wb_stat),
    .irq_pulse(irq), .busy(busy)
  );

  task automatic chk(input bit ok, input string req,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference, advanced each rising edge.
  bit m_wait, m_done, m_stat, m_pend, m_irq;
  always @(posedge clk) begin
    bit nxt_irq, noted, d, s;
    nxt_irq = 0;
    if (!rst_n) begin
      m_wait = 0; m_done = 0; m_stat = 0; m_pend = 0;
    end else if (m_wait) begin
      if (ack) begin m_wait = 0; nxt_irq = m_pend; end
    end else if (valid) begin
      noted = (c_mark == 0) ? 1 : dreq;
      if (err) nxt_irq = 1;
      else begin
        d = noted & c_wb;
        s = c_sall | (c_sicv & icv);
        if (d | s) begin
          m_wait = 1; m_done = d; m_stat = s; m_pend = noted & c_irq;
        end else nxt_irq = noted & c_irq;
      end
    end
    m_irq = nxt_irq;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq == m_irq, "R8 irq_pulse vs model", irq, m_irq);
      chk(wb_req == m_wait, "R10 wb_req vs model", wb_req, m_wait);
      chk(busy == m_wait, "R11 busy vs model", busy, m_wait);
      if (m_wait) begin
        chk(wb_code == (m_done ? CODE : 8'h00), "R3 done code vs model",
            wb_code, m_done ? CODE : 8'h00);
        chk(wb_stat == m_stat, "R5 status flag vs model", wb_stat, m_stat);
      end
    end
  end

  // One-cycle strobe; returns at the negedge after the accepting edge.
  task automatic strobe(input bit e, input bit r, input bit i);
    err = e; dreq = r; icv = i; valid = 1;
    @(negedge clk);
    valid = 0; err = 0; dreq = 0; icv = 0;
  endtask

  task automatic do_ack();
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  task automatic set_cfg(input bit a, input bit b, input bit m,
                         input bit s, input bit v);
    c_irq = a; c_wb = b; c_mark = m; c_sall = s; c_sicv = v;
  endtask

  initial begin
    #(5 * 5000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!irq && !wb_req && !busy, "R1 reset outputs", {irq, wb_req, busy}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 interrupt only
    set_cfg(1, 0, 0, 0, 0);
    strobe(0, 0, 0);
    chk(irq == 1 && !wb_req, "R2 irq after strobe", irq, 1);
    @(negedge clk);
    chk(irq == 0, "R2 irq one cycle", irq, 0);
    set_cfg(0, 0, 0, 0, 0);
    strobe(0, 1, 1);
    chk(!irq && !wb_req, "R2 disabled gives nothing", {irq, wb_req}, 0);

    // R3 done write, hold, R11 busy drop
    set_cfg(0, 1, 0, 0, 0);
    strobe(0, 0, 0);
    chk(wb_req && wb_code == CODE && !wb_stat, "R3 done write", wb_code, CODE);
    repeat (3) @(negedge clk);
    chk(wb_req && busy, "R10 held without ack", {wb_req, busy}, 3);
    set_cfg(1, 1, 0, 1, 0);
    strobe(1, 0, 0);
    chk(!irq && wb_req && !wb_stat, "R11 strobe dropped while busy", {irq, wb_stat}, 0);
    do_ack();
    chk(!wb_req && !irq, "R10 release on ack", {wb_req, irq}, 0);
    @(negedge clk);
    chk(!wb_req && !irq, "R11 no trace of dropped strobe", {wb_req, irq}, 0);

    // R4 marked-only
    set_cfg(1, 1, 1, 0, 0);
    strobe(0, 0, 0);
    chk(!irq && !wb_req, "R4 unmarked suppressed", {irq, wb_req}, 0);
    strobe(0, 1, 0);
    chk(wb_req && wb_code == CODE, "R4 marked written", wb_code, CODE);
    do_ack();
    chk(irq && !wb_req, "R8 irq after ack", irq, 1);
    // strobe right after ack, while the pulse is out
    set_cfg(0, 0, 0, 1, 0);
    strobe(0, 0, 0);
    chk(!irq && wb_req && wb_stat && wb_code == 0, "R5 status write any desc", wb_code, 0);
    do_ack();

    // R6 integrity-only status
    set_cfg(0, 0, 0, 0, 1);
    strobe(0, 1, 0);
    chk(!wb_req, "R6 no icv no write", wb_req, 0);
    strobe(0, 0, 1);
    chk(wb_req && wb_stat, "R6 icv status write", wb_stat, 1);
    do_ack();

    // R7 merged
    set_cfg(1, 1, 0, 1, 0);
    strobe(0, 0, 0);
    chk(wb_req && wb_stat && wb_code == CODE && !irq, "R7 merged request", wb_code, CODE);
    @(negedge clk);
    do_ack();
    chk(irq && !wb_req, "R8 irq follows merged ack", irq, 1);
    @(negedge clk);
    chk(!irq, "R8 pulse single", irq, 0);

    // R9 errors
    set_cfg(0, 1, 1, 1, 1);
    strobe(1, 0, 1);
    chk(irq && !wb_req, "R9 error irq no write", {irq, wb_req}, 2);
    set_cfg(0, 0, 1, 0, 0);
    strobe(1, 0, 0);
    chk(irq, "R9 error in marked mode", irq, 1);
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule